// File: doc/BRIEF.md
# Sector Modify-Protection Loader

This block holds the per-sector write/erase protection of a non-volatile memory array. While reset is active every sector is protected. Once reset is released, the block issues a single read to a non-volatile configuration store. It then copies the returned protection word into volatile registers. Those registers drive a protect bit for each sector and decide every program or erase request that arrives afterwards.

A program or erase request names a sector. One cycle later the block answers with exactly one of two pulses: an issue pulse, which lets the operation go ahead, or a deny pulse, which blocks it. Until the initial load has finished, every request is denied.

After the load, software may update the volatile copy through a write port. A plain write can only add protection, because the new value is ORed into the register. A write made while the unlock input is held replaces the register outright. The stored non-volatile word itself is program-only and is outside this block. The width of the protection word equals the number of sectors.

Top module: `sect_prot_loader`

## Requirements
- R1: While reset is asserted, `prot_vec` is all ones, `load_done` is 0, `nv_req` is 0, and neither `op_issue` nor `op_deny` is high.
- R2: `nv_req` goes high on the first clock edge after reset release and stays high up to and including the cycle in which `nv_ack` is seen. It then never rises again until the next reset.
- R3: If `nv_ack` is high while `nv_req` is high, then after the next edge `prot_vec` equals the `nv_rdata` sampled in that cycle and `load_done` is 1. A protect bit of 1 means the sector is protected, and bit i belongs to sector i.
- R4: A request accepted while `load_done` is 0 always produces `op_deny`, never `op_issue`.
- R5: When `op_valid` is high in a cycle and `load_done` is 1, the next cycle has a one-cycle pulse on exactly one output. That output is `op_deny` if bit `op_sector` of `prot_vec` was 1 in the request cycle, and `op_issue` otherwise.
- R6: After the load, a software write with `sw_unlock` at 0 makes `prot_vec` the OR of its old value and `sw_wr_data` from the next cycle on. No protect bit is ever cleared this way.
- R7: After the load, a software write with `sw_unlock` at 1 makes `prot_vec` equal to `sw_wr_data` from the next cycle on.
- R8: Software writes made while `load_done` is 0 have no effect on `prot_vec`.
- R9: In a cycle where `op_valid` is 0, neither `op_issue` nor `op_deny` pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| nv_req | output | 1 | Read request to the non-volatile store |
| nv_addr | output | NV_AW | Fixed address of the protection word |
| nv_ack | input | 1 | Read acknowledge; `nv_rdata` is valid in this cycle |
| nv_rdata | input | 2**SECT_W | Protection word read from the store |
| load_done | output | 1 | Initial load complete |
| prot_vec | output | 2**SECT_W | Per-sector protect bits (1 = protected) |
| op_valid | input | 1 | Program or erase request present |
| op_sector | input | SECT_W | Sector targeted by the request |
| op_issue | output | 1 | One-cycle pulse: operation allowed |
| op_deny | output | 1 | One-cycle pulse: operation rejected |
| sw_wr_en | input | 1 | Software write strobe for the volatile registers |
| sw_unlock | input | 1 | Unlock condition: write replaces instead of ORing |
| sw_wr_data | input | 2**SECT_W | Software write data |

## Verification
A corrupted protect register shows up on `prot_vec` in the cycle after the bad update. It also shows up as a wrong issue or deny pulse one cycle after any request to that sector, so stimulus that targets every sector exposes it quickly. A load state machine stuck or re-entered shows as `nv_req` held high, or rising again, after `load_done`. It can also show as issue pulses appearing before the load, in the first cycle that carries a request. Dropping the OR on a locked write clears a bit visibly in the next cycle.

// File: rtl/sect_prot_pkg.sv
package sect_prot_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_REQ  = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/sect_prot_fetch.sv
module sect_prot_fetch
  import sect_prot_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 8,
  parameter int NV_ADDR = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          nv_req,
  output logic [AW-1:0] nv_addr,
  input  logic          nv_ack,
  input  logic [DW-1:0] nv_rdata,
  output logic          cap_en,
  output logic [DW-1:0] cap_data,
  output logic          load_done
);
  ld_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      LD_IDLE: state_d = LD_REQ;
      LD_REQ:  if (nv_ack) state_d = LD_DONE;
      LD_DONE: state_d = LD_DONE;
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LD_IDLE;
    else        state_q <= state_d;
  end

  assign nv_req    = (state_q == LD_REQ);
  assign nv_addr   = AW'(NV_ADDR);
  assign cap_en    = (state_q == LD_REQ) && nv_ack;
  assign cap_data  = nv_rdata;
  assign load_done = (state_q == LD_DONE);
endmodule

// File: rtl/sect_prot_regs.sv
module sect_prot_regs #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  logic [N-1:0] cap_data,
  input  logic         load_done,
  input  logic         sw_wr_en,
  input  logic         sw_unlock,
  input  logic [N-1:0] sw_wr_data,
  output logic [N-1:0] prot_q
);
  logic [N-1:0] prot_d;
  logic         prot_en;

  always_comb begin
    prot_en = 1'b0;
    prot_d  = prot_q;
    if (cap_en) begin
      prot_en = 1'b1;
      prot_d  = cap_data;
    end else if (load_done && sw_wr_en) begin
      prot_en = 1'b1;
      prot_d  = sw_unlock ? sw_wr_data : (prot_q | sw_wr_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prot_q <= '1;
    else if (prot_en) prot_q <= prot_d;
  end
endmodule

// File: rtl/sect_prot_gate.sv
module sect_prot_gate #(
  parameter int SW = 4,
  localparam int N = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_done,
  input  logic [N-1:0]  prot,
  input  logic          op_valid,
  input  logic [SW-1:0] op_sector,
  output logic          op_issue,
  output logic          op_deny
);
  logic blocked, issue_d, deny_d;

  always_comb begin
    blocked = !load_done || prot[op_sector];
    issue_d = op_valid && !blocked;
    deny_d  = op_valid && blocked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_issue <= 1'b0;
      op_deny  <= 1'b0;
    end else begin
      op_issue <= issue_d;
      op_deny  <= deny_d;
    end
  end
endmodule

// File: rtl/sect_prot_loader.sv
module sect_prot_loader #(
  parameter int SECT_W  = 4,
  parameter int NV_AW   = 8,
  parameter int NV_ADDR = 16,
  localparam int NSECT  = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              nv_req,
  output logic [NV_AW-1:0]  nv_addr,
  input  logic              nv_ack,
  input  logic [NSECT-1:0]  nv_rdata,
  output logic              load_done,
  output logic [NSECT-1:0]  prot_vec,
  input  logic              op_valid,
  input  logic [SECT_W-1:0] op_sector,
  output logic              op_issue,
  output logic              op_deny,
  input  logic              sw_wr_en,
  input  logic              sw_unlock,
  input  logic [NSECT-1:0]  sw_wr_data
);
  logic             cap_en;
  logic [NSECT-1:0] cap_data;

  sect_prot_fetch #(.DW(NSECT), .AW(NV_AW), .NV_ADDR(NV_ADDR)) u_fetch (
    .clk(clk), .rst_n(rst_n), .nv_req(nv_req), .nv_addr(nv_addr),
    .nv_ack(nv_ack), .nv_rdata(nv_rdata), .cap_en(cap_en),
    .cap_data(cap_data), .load_done(load_done)
  );

  sect_prot_regs #(.N(NSECT)) u_regs (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_data(cap_data),
    .load_done(load_done), .sw_wr_en(sw_wr_en), .sw_unlock(sw_unlock),
    .sw_wr_data(sw_wr_data), .prot_q(prot_vec)
  );

  sect_prot_gate #(.SW(SECT_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .load_done(load_done), .prot(prot_vec),
    .op_valid(op_valid), .op_sector(op_sector),
    .op_issue(op_issue), .op_deny(op_deny)
  );
endmodule

// File: rtl/sect_prot_loader_chk.sv
module sect_prot_loader_chk #(
  parameter int SECT_W  = 4,
  localparam int NSECT  = 1 << SECT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nv_req,
  input logic              nv_ack,
  input logic              load_done,
  input logic [NSECT-1:0]  prot_vec,
  input logic              op_valid,
  input logic [SECT_W-1:0] op_sector,
  input logic              op_issue,
  input logic              op_deny,
  input logic              sw_wr_en,
  input logic              sw_unlock
);
  AST_PROT_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |-> (&prot_vec)); // R1
  AST_REQ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    load_done |-> !nv_req); // R2
  AST_ACK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req && nv_ack) |=> load_done); // R3
  AST_NO_ISSUE_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    !load_done |=> !op_issue); // R4
  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (op_issue ^ op_deny)); // R5
  AST_ISSUE_UNPROT: assert property (@(posedge clk) disable iff (!rst_n)
    op_issue |-> $past(!prot_vec[op_sector])); // R5
  AST_NO_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && $past(load_done) && !($past(sw_wr_en) && $past(sw_unlock)))
      |-> ((~prot_vec & $past(prot_vec)) == '0)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !(op_issue || op_deny)); // R9
endmodule

bind sect_prot_loader sect_prot_loader_chk #(.SECT_W(SECT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nv_req(nv_req), .nv_ack(nv_ack),
  .load_done(load_done), .prot_vec(prot_vec), .op_valid(op_valid),
  .op_sector(op_sector), .op_issue(op_issue), .op_deny(op_deny),
  .sw_wr_en(sw_wr_en), .sw_unlock(sw_unlock)
);

// File: tb/tb_sect_prot_loader.sv
module tb_sect_prot_loader;
  localparam int SW = 4;
  localparam int N  = 1 << SW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          nv_req, nv_ack, load_done, op_valid, op_issue, op_deny;
  logic          sw_wr_en, sw_unlock;
  logic [7:0]    nv_addr;
  logic [N-1:0]  nv_rdata, prot_vec, sw_wr_data;
  logic [SW-1:0] op_sector;

  int n_tests = 0;
  int n_fail  = 0;

  // bench model state
  int           m_st;       // 0 idle, 1 requesting, 2 loaded
  logic [N-1:0] m_prot;
  logic         m_issue, m_deny;

  always #4 clk = ~clk;

  sect_prot_loader #(.SECT_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .nv_req(nv_req), .nv_addr(nv_addr),
    .nv_ack(nv_ack), .nv_rdata(nv_rdata), .load_done(load_done),
    .prot_vec(prot_vec), .op_valid(op_valid), .op_sector(op_sector),
    .op_issue(op_issue), .op_deny(op_deny), .sw_wr_en(sw_wr_en),
    .sw_unlock(sw_unlock), .sw_wr_data(sw_wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] next_prot(input logic [N-1:0] cur, input logic [N-1:0] d,
                                             input logic unl);
    return unl ? d : (cur | d);
  endfunction

  // one clock: update model from the inputs now applied, then compare at negedge
  task automatic step();
    @(posedge clk);
    m_issue = op_valid && (m_st == 2) && !m_prot[op_sector];
    m_deny  = op_valid && !((m_st == 2) && !m_prot[op_sector]);
    if (m_st == 0) m_st = 1;
    else if (m_st == 1) begin
      if (nv_ack) begin m_st = 2; m_prot = nv_rdata; end
    end else if (sw_wr_en) m_prot = next_prot(m_prot, sw_wr_data, sw_unlock);
    @(negedge clk);
    check("R2 nv_req", {31'd0, nv_req}, {31'd0, m_st == 1});
    check("R3 load_done", {31'd0, load_done}, {31'd0, m_st == 2});
    check("R6/R7/R8 prot_vec", 32'(prot_vec), 32'(m_prot));
    check("R4/R5/R9 op_issue", {31'd0, op_issue}, {31'd0, m_issue});
    check("R4/R5/R9 op_deny", {31'd0, op_deny}, {31'd0, m_deny});
  endtask

  task automatic idle_in();
    op_valid = 0; op_sector = '0; sw_wr_en = 0; sw_unlock = 0; sw_wr_data = '0;
    nv_ack = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    rst_n = 0; nv_rdata = '0;
    idle_in();
    m_st = 0; m_prot = '1; m_issue = 0; m_deny = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 prot_vec", 32'(prot_vec), 32'(16'hFFFF));
    check("R1 load_done", {31'd0, load_done}, 32'd0);
    check("R1 nv_req", {31'd0, nv_req}, 32'd0);
    check("R1 pulses", {30'd0, op_issue, op_deny}, 32'd0);
    rst_n = 1;
    // waiting for the store: requests denied (R4), writes ignored (R8)
    for (int i = 0; i < 6; i++) begin
      op_valid = 1; op_sector = SW'(i);
      sw_wr_en = 1; sw_unlock = 1; sw_wr_data = 16'h0000;
      step();
    end
    // acknowledge with a request in the same cycle: still denied (R4)
    nv_ack = 1; nv_rdata = 16'h0F0A; op_valid = 1; op_sector = 4'd0;
    sw_wr_en = 1; sw_unlock = 1; sw_wr_data = '0;
    step();
    idle_in();
    check("R3 loaded word", 32'(prot_vec), 32'(16'h0F0A));
    // late ack must not reload (R2)
    nv_ack = 1; nv_rdata = 16'hFFFF;
    step();
    idle_in();
    // directed: sector 0 is free, sector 1 is protected (R5)
    op_valid = 1; op_sector = 4'd0; step();
    check("R5 issue sector0", {31'd0, op_issue}, 32'd1);
    op_sector = 4'd1; step();
    check("R5 deny sector1", {31'd0, op_deny}, 32'd1);
    op_valid = 0;
    // locked write of zeros changes nothing (R6)
    sw_wr_en = 1; sw_unlock = 0; sw_wr_data = '0; step();
    check("R6 zero write no effect", 32'(prot_vec), 32'(16'h0F0A));
    // unlock clears all (R7), then last sector issues
    sw_unlock = 1; step();
    check("R7 unlock write", 32'(prot_vec), 32'd0);
    sw_wr_en = 0; op_valid = 1; op_sector = 4'd15; step();
    check("R5 issue sector15", {31'd0, op_issue}, 32'd1);
    // locked write sets sector 15, request in same cycle sees old value (R5, R6)
    sw_wr_en = 1; sw_unlock = 0; sw_wr_data = 16'h8000; op_sector = 4'd15; step();
    check("R5 old value used", {31'd0, op_issue}, 32'd1);
    sw_wr_en = 0; step();
    check("R6 set bit then deny", {31'd0, op_deny}, 32'd1);
    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      op_valid   = ($urandom % 3) != 0;
      op_sector  = SW'($urandom);
      sw_wr_en   = ($urandom % 4) == 0;
      sw_unlock  = ($urandom % 3) == 0;
      sw_wr_data = N'($urandom) & N'($urandom);
      nv_ack     = ($urandom % 5) == 0;
      nv_rdata   = N'($urandom);
      step();
    end
    idle_in();
    step();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule